// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Register

This block holds the per-endpoint event flags that a USB device controller reports to its CPU for two bulk-IN endpoints and one interrupt-IN endpoint. The packet engine pulses one-cycle strobes when an IN token is answered with NAK, when a bulk transmit FIFO swaps and can take new data, and when the host acknowledges an interrupt-IN packet. Each strobe sets its flag. The CPU reads the flags as one 8-bit read-only status value.

A flag clears in one of three ways. The CPU can write 0 to the matching bit of a companion clear register. The first CPU write into the endpoint's transmit buffer also clears its flag. Reset clears all flags. The block drives a level interrupt request while any valid flag is set. It pulses a change event for one cycle whenever the stored value changes. Endpoint-enable inputs mark flags of unsupported endpoints as invalid. Invalid flags are forced to 0 and are kept out of the interrupt request.

Top module: `usb_ep_irq_status`

## Requirements
- R1: After reset the status value is 0x00, the interrupt request is low and the change event is low.
- R2: A NAK strobe for bulk endpoint 0 sets status bit 5, and for bulk endpoint 1 sets bit 7. The bit is visible one clock after the strobe.
- R3: A buffer-ready strobe for bulk endpoint 0 sets bit 4, and for bulk endpoint 1 sets bit 6. A CPU write to that endpoint's transmit buffer clears the bit on the next clock. A later write while the bit is 0 changes nothing.
- R4: A transmit-done strobe for the interrupt endpoint sets bit 0. A CPU write to that endpoint's transmit buffer clears it on the next clock.
- R5: A clear-register write forces each status bit whose written data bit is 0 to 0. Bits written with 1 keep their value.
- R6: When a set strobe and a clear (clear-register 0 or buffer write) hit the same bit in the same cycle, the bit ends up 1.
- R7: `chg_evt` is high for exactly the one cycle in which `status` differs from its value in the previous cycle.
- R8: Status bits 3 to 1 always read 0.
- R9: While an endpoint's enable is low, its flags become 0 on the next clock, stay 0 under set strobes, and never drive `irq`. `irq` drops in the same cycle the enable falls.
- R10: `irq` is high exactly when any status bit of an enabled endpoint is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bulk_en | input | 2 | Bulk endpoint enables (bit k = bulk endpoint k) |
| intr_en | input | 1 | Interrupt endpoint enable |
| bulk_nak_set | input | 2 | NAK-returned strobe per bulk endpoint |
| bulk_rdy_set | input | 2 | FIFO-swapped strobe per bulk endpoint |
| intr_done_set | input | 1 | Interrupt packet acknowledged strobe |
| bulk_buf_wr | input | 2 | CPU write access to a bulk transmit buffer |
| intr_buf_wr | input | 1 | CPU write access to the interrupt transmit buffer |
| clr_wr | input | 1 | Write strobe of the clear register |
| clr_data | input | 8 | Clear register data, 0 clears the matching bit |
| status | output | 8 | Status flags |
| irq | output | 1 | Summary interrupt request |
| chg_evt | output | 1 | One-cycle pulse on any status change |

## Verification
The colliding functions are setting a flag and clearing it. A hardware strobe can meet either a clear-register write of 0 or a CPU buffer write in the same cycle. The bench drives both collisions on one clock edge while other flags are clearing. It judges the result one edge later: the struck bit must still be 1, and its neighbours must be cleared. The change pulse must reflect only the bits that actually moved.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int INTR_BIT  = 0;
  localparam int BULK_BASE = 4;

  function automatic int status_width(input int nbulk);
    return BULK_BASE + 2 * nbulk;
  endfunction
endpackage

// File: rtl/usb_irq_rst_sync.sv
module usb_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/usb_irq_flag_cell.sv
module usb_irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic set_i,
  input  logic clr_i,
  output logic next_o,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_d = flag_q;
    if (!valid_i)    flag_d = 1'b0;
    else if (set_i)  flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
    flag_en = flag_d ^ flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign next_o = flag_d;
  assign flag_o = flag_q;

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && set_i) |=> flag_o);
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !set_i && clr_i) |=> !flag_o);
  a_r9_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !flag_o);
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/usb_irq_evt_gen.sv
module usb_irq_evt_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_d,
  input  logic [W-1:0] stat_q,
  input  logic [W-1:0] valid_mask,
  output logic         chg_evt,
  output logic         irq
);
  logic chg_q;
  logic chg_d;

  always_comb begin
    chg_d = (stat_d != stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_d;
  end

  assign chg_evt = chg_q;
  assign irq     = |(stat_q & valid_mask);

  always_comb begin
    if (rst_n && irq) a_r10_irq_has_source: assert (stat_q != '0);
  end
endmodule

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status
  import usb_irq_pkg::*;
#(
  parameter int NUM_BULK = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_BULK-1:0]                     bulk_en,
  input  logic                                    intr_en,
  input  logic [NUM_BULK-1:0]                     bulk_nak_set,
  input  logic [NUM_BULK-1:0]                     bulk_rdy_set,
  input  logic                                    intr_done_set,
  input  logic [NUM_BULK-1:0]                     bulk_buf_wr,
  input  logic                                    intr_buf_wr,
  input  logic                                    clr_wr,
  input  logic [BULK_BASE+2*NUM_BULK-1:0]         clr_data,
  output logic [BULK_BASE+2*NUM_BULK-1:0]         status,
  output logic                                    irq,
  output logic                                    chg_evt
);
  localparam int W = BULK_BASE + 2 * NUM_BULK;

  logic         rst_q;
  logic [W-1:0] stat_d;
  logic [W-1:0] stat_q;
  logic [W-1:0] valid_mask;

  usb_irq_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == INTR_BIT) begin : g_intr
      usb_irq_flag_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_q),
        .valid_i (intr_en),
        .set_i   (intr_done_set),
        .clr_i   ((clr_wr & ~clr_data[i]) | intr_buf_wr),
        .next_o  (stat_d[i]),
        .flag_o  (stat_q[i])
      );
      assign valid_mask[i] = intr_en;
    end else if (i >= BULK_BASE) begin : g_bulk
      localparam int K     = (i - BULK_BASE) / 2;
      localparam bit ISNAK = ((i - BULK_BASE) % 2) == 1;
      logic set_w;
      logic hwclr_w;
      if (ISNAK) begin : g_nak
        assign set_w   = bulk_nak_set[K];
        assign hwclr_w = 1'b0;
      end else begin : g_rdy
        assign set_w   = bulk_rdy_set[K];
        assign hwclr_w = bulk_buf_wr[K];
      end
      usb_irq_flag_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_q),
        .valid_i (bulk_en[K]),
        .set_i   (set_w),
        .clr_i   ((clr_wr & ~clr_data[i]) | hwclr_w),
        .next_o  (stat_d[i]),
        .flag_o  (stat_q[i])
      );
      assign valid_mask[i] = bulk_en[K];
    end else begin : g_unused
      assign stat_d[i]     = 1'b0;
      assign stat_q[i]     = 1'b0;
      assign valid_mask[i] = 1'b0;
    end
  end

  usb_irq_evt_gen #(.W(W)) u_evt (
    .clk        (clk),
    .rst_n      (rst_q),
    .stat_d     (stat_d),
    .stat_q     (stat_q),
    .valid_mask (valid_mask),
    .chg_evt    (chg_evt),
    .irq        (irq)
  );

  assign status = stat_q;

  a_r7_change_pulses: assert property (@(posedge clk) disable iff (!rst_q)
    (status != $past(status)) |-> chg_evt);
  a_r7_quiet_no_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    (status == $past(status)) |-> !chg_evt);
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_q)
    status[BULK_BASE-1:INTR_BIT+1] == '0);
  a_r2_nak_sets: assert property (@(posedge clk) disable iff (!rst_q)
    (bulk_en[0] && bulk_nak_set[0]) |=> status[BULK_BASE+1]);
  a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_q)
    (intr_en && intr_done_set) |=> status[INTR_BIT]);
endmodule

// File: tb/usb_ep_irq_status_test.sv
`timescale 1ns/100ps
module usb_ep_irq_status_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bulk_en;
  logic       intr_en;
  logic [1:0] bulk_nak_set, bulk_rdy_set, bulk_buf_wr;
  logic       intr_done_set, intr_buf_wr, clr_wr;
  logic [7:0] clr_data;
  logic [7:0] status;
  logic       irq, chg_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  usb_ep_irq_status uut (
    .clk(clk), .rst_n(rst_n), .bulk_en(bulk_en), .intr_en(intr_en),
    .bulk_nak_set(bulk_nak_set), .bulk_rdy_set(bulk_rdy_set),
    .intr_done_set(intr_done_set), .bulk_buf_wr(bulk_buf_wr),
    .intr_buf_wr(intr_buf_wr), .clr_wr(clr_wr), .clr_data(clr_data),
    .status(status), .irq(irq), .chg_evt(chg_evt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bulk_nak_set = '0; bulk_rdy_set = '0; bulk_buf_wr = '0;
    intr_done_set = 1'b0; intr_buf_wr = 1'b0; clr_wr = 1'b0; clr_data = 8'hFF;
  endtask

  // inputs are set at a falling edge; one rising edge, then back to the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = 8'h00; tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 evt", {7'd0, chg_evt}, 8'h00);
  endtask

  task automatic t_nak();
    bulk_nak_set = 2'b01; tick();
    chk("R2 nak ep0", status, 8'h20);
    chk("R7 evt on set", {7'd0, chg_evt}, 8'h01);
    chk("R10 irq", {7'd0, irq}, 8'h01);
    tick();
    chk("R7 evt one cycle", {7'd0, chg_evt}, 8'h00);
    bulk_nak_set = 2'b10; tick();
    chk("R2 nak ep1", status, 8'hA0);
    clear_all();
  endtask

  task automatic t_ready();
    bulk_rdy_set = 2'b10; tick();
    chk("R3 rdy ep1", status, 8'h40);
    bulk_rdy_set = 2'b01; tick();
    chk("R3 rdy ep0", status, 8'h50);
    bulk_buf_wr = 2'b10; tick();
    chk("R3 buf write clears", status, 8'h10);
    bulk_buf_wr = 2'b10; tick();
    chk("R3 second write no change", status, 8'h10);
    chk("R3 second write no evt", {7'd0, chg_evt}, 8'h00);
    clear_all();
  endtask

  task automatic t_done();
    intr_done_set = 1'b1; tick();
    chk("R4 done set", status, 8'h01);
    chk("R10 irq done", {7'd0, irq}, 8'h01);
    intr_buf_wr = 1'b1; tick();
    chk("R4 buf write clears", status, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_clear_reg();
    bulk_nak_set = 2'b11; bulk_rdy_set = 2'b11; intr_done_set = 1'b1; tick();
    chk("R8 unused low after all sets", status, 8'hF1);
    clr_wr = 1'b1; clr_data = 8'hFF; tick();
    chk("R5 write ones keeps", status, 8'hF1);
    chk("R5 no evt on ones", {7'd0, chg_evt}, 8'h00);
    clr_wr = 1'b1; clr_data = 8'h7F; tick();
    chk("R5 clear bit7", status, 8'h71);
    clr_wr = 1'b1; clr_data = 8'h0E; tick();
    chk("R5 clear rest", status, 8'h00);
    chk("R10 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collide();
    bulk_rdy_set = 2'b11; tick();
    // set nak0 against clear-reg zero on bit5 and bit4; set rdy1 against buffer write
    bulk_nak_set = 2'b01; bulk_rdy_set = 2'b10; bulk_buf_wr = 2'b10;
    clr_wr = 1'b1; clr_data = 8'hCF; tick();
    chk("R6 set beats clears", status, 8'h60);
    chk("R7 evt on collision", {7'd0, chg_evt}, 8'h01);
    clear_all();
  endtask

  task automatic t_disable();
    bulk_nak_set = 2'b01; tick();
    chk("R9 pre", status, 8'h20);
    bulk_en = 2'b10;
    #0.5;
    chk("R9 irq drops at once", {7'd0, irq}, 8'h00);
    tick();
    chk("R9 flag forced 0", status, 8'h00);
    chk("R7 evt on drop", {7'd0, chg_evt}, 8'h01);
    bulk_nak_set = 2'b01; bulk_rdy_set = 2'b01; tick();
    chk("R9 set ignored", status, 8'h00);
    chk("R9 no irq", {7'd0, irq}, 8'h00);
    bulk_en = 2'b11; tick();
    bulk_rdy_set = 2'b01; tick();
    chk("R9 reenabled works", status, 8'h10);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; bulk_en = 2'b11; intr_en = 1'b1; idle_inputs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nak();
    t_ready();
    t_done();
    t_clear_reg();
    t_collide();
    t_disable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule